// File: doc/BRIEF.md
# Masked Sticky Error Status Latch

This block gathers per-cycle error flags raised elsewhere in a serial video receive path and turns them into one active-low summary error output, all in the parallel pixel clock domain. Every error source has an enable bit in a mask register, and only enabled sources are recorded. Recorded errors go into a sticky status register, and each bit in it stays set until a clear event.

There are two clear events. One is the start-of-frame or start-of-field strobe from the timing decoder. The other is a host read of the status register. The summary output is low whenever the sticky register holds any bit. A host drives a small register port with address, read strobe, write strobe and data to read the status register and to read or write the mask. The block does not detect errors itself. The individual error checks reach it as input flags.

Top module: `err_status_latch`

## Requirements
- R1: After reset, `err_n` is 1, the status register is 0, all mask bits are 1, and `host_rdata` is 0.
- R2: A flag on an input bit whose mask bit is 1 sets the matching status bit at the next clock edge, and `err_n` is 0 from that edge on.
- R3: A flag on an input bit whose mask bit is 0 changes neither the status register nor `err_n`.
- R4: While no clear event occurs, `err_n` stays 0 once a status bit has been set.
- R5: A `frame_start` pulse clears every status bit at the next edge. `err_n` then returns to 1 unless a new enabled flag arrives in that same cycle.
- R6: A read with `host_addr` 0 (status) clears the status register at the edge it is sampled. At that edge, `host_rdata[7:0]` takes the status value from before the clear, and `host_rdata[15:8]` takes 0.
- R7: When an enabled flag arrives in the same cycle as a clear, the set wins. That bit is 1 after the edge, and `err_n` stays 0.
- R8: A write with `host_addr` 1 (mask) loads `host_wdata` into the mask at the edge. A read with `host_addr` 1 returns the mask in `host_rdata[7:0]` and has no effect on the status register. The new mask applies to flags from the following cycle on.
- R9: A write to address 0, 2 or 3 has no effect. A read of address 2 or 3 returns 0 and does not clear the status register.
- R10: `err_n` is the inverted OR of all status bits. Each set bit alone drives it low, and it is 1 only when all bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_flags | input | 8 | Per-cycle error flags, one bit per source |
| frame_start | input | 1 | One-cycle strobe at the start of a frame or field |
| host_addr | input | 2 | Register address: 0 status, 1 mask |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 8 | Write data for the mask register |
| host_rdata | output | 16 | Registered read data, held until the next read |
| err_n | output | 1 | Active-low summary of recorded errors |

## Verification
Each result is due exactly one clock edge after its stimulus. A flag, a `frame_start` pulse or a status read changes the status register and `err_n` at the first rising edge that samples it. `host_rdata` is loaded at that same edge, and a mask write affects flags sampled at the following edge. The bench changes inputs on the falling edge and samples outputs on the next falling edge, so every check sees the state just after the single edge that applies the stimulus. Collision cases put a flag and a clear into the same sampled cycle to show which takes precedence at that edge.

// File: rtl/esl_pkg.sv
// Shared constants for the error status latch.
// Assumes a two-bit register address space; only two addresses are decoded.
package esl_pkg;
    localparam int unsigned ESL_ADDR_W      = 2;
    localparam logic [ESL_ADDR_W-1:0] ESL_ADDR_STATUS = 2'd0;
    localparam logic [ESL_ADDR_W-1:0] ESL_ADDR_MASK   = 2'd1;

    // Decoded host access for one cycle.
    typedef struct packed {
        logic status_rd;
        logic mask_rd;
        logic mask_wr;
    } esl_access_t;
endpackage

// File: rtl/esl_mask_reg.sv
// Mask register: one enable bit per error source.
// Resets to all ones so every source is monitored; loaded by a decoded host write.
module esl_mask_reg #(
    parameter int unsigned NUM_ERR = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [NUM_ERR-1:0] load_val,
    output logic [NUM_ERR-1:0] mask_q
);
    // Hold the mask, reload it on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (load)
            mask_q <= load_val;
    end
endmodule

// File: rtl/esl_sticky_bank.sv
// Sticky status bits, one per error source.
// A bit sets on its enabled flag and clears on the shared clear; set beats clear.
module esl_sticky_bank #(
    parameter int unsigned NUM_ERR = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ERR-1:0] flags,
    input  logic [NUM_ERR-1:0] enable,
    input  logic               clr,
    output logic [NUM_ERR-1:0] status_q
);
    for (genvar i = 0; i < NUM_ERR; i++) begin : g_bit
        logic set_i;
        assign set_i = flags[i] & enable[i];

        // Update one sticky bit: clear first, then the set overrides.
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_q[i] <= 1'b0;
            else if (set_i)
                status_q[i] <= 1'b1;
            else if (clr)
                status_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/esl_host_port.sv
// Host register port: decodes strobes and registers the read data.
// Assumes single-cycle strobes; read data holds until the next read.
module esl_host_port
    import esl_pkg::*;
#(
    parameter int unsigned NUM_ERR = 8,
    parameter int unsigned DATA_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ESL_ADDR_W-1:0] addr,
    input  logic                  rd,
    input  logic                  wr,
    input  logic [NUM_ERR-1:0]    status_q,
    input  logic [NUM_ERR-1:0]    mask_q,
    output esl_access_t           acc,
    output logic [DATA_W-1:0]     rdata
);
    localparam int unsigned PAD_W = DATA_W - NUM_ERR;

    logic [NUM_ERR-1:0] rd_sel;

    // Decode the access type from address and strobes.
    always_comb begin
        acc.status_rd = rd && (addr == ESL_ADDR_STATUS);
        acc.mask_rd   = rd && (addr == ESL_ADDR_MASK);
        acc.mask_wr   = wr && (addr == ESL_ADDR_MASK);
    end

    // Select the register being read; unmapped addresses give zero.
    always_comb begin
        rd_sel = '0;
        if (acc.status_rd)
            rd_sel = status_q;
        else if (acc.mask_rd)
            rd_sel = mask_q;
    end

    // Capture the pre-clear value on any read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd)
            rdata <= {{PAD_W{1'b0}}, rd_sel};
    end
endmodule

// File: rtl/err_status_latch.sv
// Error status latch with mask: records enabled error flags in a sticky
// register, drives an active-low summary, and clears on frame start or on
// a host read of the status register.
// Assumes all inputs are synchronous to clk.
module err_status_latch
    import esl_pkg::*;
#(
    parameter int unsigned NUM_ERR = 8,
    parameter int unsigned DATA_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_ERR-1:0]    err_flags,
    input  logic                  frame_start,
    input  logic [ESL_ADDR_W-1:0] host_addr,
    input  logic                  host_rd,
    input  logic                  host_wr,
    input  logic [NUM_ERR-1:0]    host_wdata,
    output logic [DATA_W-1:0]     host_rdata,
    output logic                  err_n
);
    logic [NUM_ERR-1:0] mask_q;
    logic [NUM_ERR-1:0] status_q;
    esl_access_t        acc;
    logic               clr;

    esl_host_port #(.NUM_ERR(NUM_ERR), .DATA_W(DATA_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (host_addr),
        .rd       (host_rd),
        .wr       (host_wr),
        .status_q (status_q),
        .mask_q   (mask_q),
        .acc      (acc),
        .rdata    (host_rdata)
    );

    esl_mask_reg #(.NUM_ERR(NUM_ERR)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc.mask_wr),
        .load_val (host_wdata),
        .mask_q   (mask_q)
    );

    // Either clear source releases the sticky register.
    assign clr = frame_start | acc.status_rd;

    esl_sticky_bank #(.NUM_ERR(NUM_ERR)) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags    (err_flags),
        .enable   (mask_q),
        .clr      (clr),
        .status_q (status_q)
    );

    // Summary output is low while any recorded error remains.
    assign err_n = ~(|status_q);
endmodule

// File: rtl/esl_checker.sv
// Checker for the error status latch; relates ports and internal
// registers across clock edges. Attached by bind below.
module esl_checker
    import esl_pkg::*;
#(
    parameter int unsigned NUM_ERR = 8,
    parameter int unsigned DATA_W  = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_ERR-1:0]    err_flags,
    input logic                  frame_start,
    input logic [ESL_ADDR_W-1:0] host_addr,
    input logic                  host_rd,
    input logic [DATA_W-1:0]     host_rdata,
    input logic                  err_n,
    input logic [NUM_ERR-1:0]    mask_q,
    input logic [NUM_ERR-1:0]    status_q
);
    logic new_err;
    logic any_clr;
    assign new_err = |(err_flags & mask_q);
    assign any_clr = frame_start | (host_rd && host_addr == ESL_ADDR_STATUS);

    // R2
    enabled_flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_err |=> !err_n);

    // R3
    masked_flag_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_n && !new_err) |=> err_n);

    // R4
    err_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_n && !any_clr) |=> !err_n);

    // R5
    clear_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_clr && !new_err) |=> err_n);

    // R6
    read_preclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == ESL_ADDR_STATUS)
        |=> (host_rdata == {{(DATA_W-NUM_ERR){1'b0}}, $past(status_q)}));

    // R7
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_clr && new_err) |=> ((status_q & $past(err_flags & mask_q)) == $past(err_flags & mask_q)));
endmodule

bind err_status_latch esl_checker #(.NUM_ERR(NUM_ERR), .DATA_W(DATA_W)) u_esl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_flags   (err_flags),
    .frame_start (frame_start),
    .host_addr   (host_addr),
    .host_rd     (host_rd),
    .host_rdata  (host_rdata),
    .err_n       (err_n),
    .mask_q      (mask_q),
    .status_q    (status_q)
);

// File: tb/tb_err_status_latch.sv
// Directed bench for the error status latch: inputs change on the falling
// edge, outputs are sampled on the next falling edge.
module tb_err_status_latch;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  err_flags;
    logic        frame_start;
    logic [1:0]  host_addr;
    logic        host_rd;
    logic        host_wr;
    logic [7:0]  host_wdata;
    logic [15:0] host_rdata;
    logic        err_n;

    int n_chk = 0;
    int n_err = 0;

    err_status_latch dut (
        .clk(clk), .rst_n(rst_n), .err_flags(err_flags), .frame_start(frame_start),
        .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .err_n(err_n)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        err_flags = '0; frame_start = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
        host_addr = '0; host_wdata = '0;
    endtask

    // One edge with the current inputs, then return to idle.
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic host_read(input logic [1:0] a, output logic [15:0] d);
        host_addr = a; host_rd = 1'b1;
        step();
        d = host_rdata;
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] v);
        host_addr = a; host_wr = 1'b1; host_wdata = v;
        step();
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 err_n", {15'd0, err_n}, 16'd1);
        check("R1 rdata", host_rdata, 16'h0000);
        host_read(2'd1, d);
        check("R1 mask", d, 16'h00FF);
        host_read(2'd0, d);
        check("R1 status", d, 16'h0000);
    endtask

    task automatic t_set_and_read();
        logic [15:0] d;
        err_flags = 8'h04; step();
        check("R2 err_n low", {15'd0, err_n}, 16'd0);
        repeat (5) step();
        check("R4 held", {15'd0, err_n}, 16'd0);
        host_read(2'd1, d);
        check("R8 mask read leaves status", {15'd0, err_n}, 16'd0);
        host_read(2'd0, d);
        check("R6 preclear value", d, 16'h0004);
        check("R6 err_n released", {15'd0, err_n}, 16'd1);
        host_read(2'd0, d);
        check("R6 cleared", d, 16'h0000);
    endtask

    task automatic t_multi_bits();
        logic [15:0] d;
        err_flags = 8'hA5; step();
        check("R10 err_n low", {15'd0, err_n}, 16'd0);
        host_read(2'd0, d);
        check("R10 status", d, 16'h00A5);
        check("R10 err_n high", {15'd0, err_n}, 16'd1);
        err_flags = 8'h80; step();
        check("R10 top bit", {15'd0, err_n}, 16'd0);
        frame_start = 1'b1; step();
        check("R5 frame clear", {15'd0, err_n}, 16'd1);
    endtask

    task automatic t_mask();
        logic [15:0] d;
        host_write(2'd1, 8'hF0);
        host_read(2'd1, d);
        check("R8 mask value", d, 16'h00F0);
        err_flags = 8'h0F; step();
        check("R3 masked err_n", {15'd0, err_n}, 16'd1);
        host_read(2'd0, d);
        check("R3 masked status", d, 16'h0000);
        err_flags = 8'h10; step();
        check("R8 enabled bit", {15'd0, err_n}, 16'd0);
        frame_start = 1'b1; step();
        check("R5 clear", {15'd0, err_n}, 16'd1);
        // Mask write and flag in the same cycle: old mask applies to that flag.
        host_addr = 2'd1; host_wr = 1'b1; host_wdata = 8'hFF; err_flags = 8'h01; step();
        check("R8 old mask on same cycle", {15'd0, err_n}, 16'd1);
        err_flags = 8'h01; step();
        check("R8 new mask next cycle", {15'd0, err_n}, 16'd0);
        frame_start = 1'b1; step();
    endtask

    task automatic t_collide();
        logic [15:0] d;
        err_flags = 8'h01; step();
        frame_start = 1'b1; err_flags = 8'h02; step();
        check("R7 frame vs set err_n", {15'd0, err_n}, 16'd0);
        // Read with a new flag: old value returned, new bit kept.
        host_addr = 2'd0; host_rd = 1'b1; err_flags = 8'h40; step();
        check("R7 read returns old", host_rdata, 16'h0002);
        check("R7 new bit kept", {15'd0, err_n}, 16'd0);
        host_read(2'd0, d);
        check("R7 new bit value", d, 16'h0040);
    endtask

    task automatic t_ignored();
        logic [15:0] d;
        host_write(2'd0, 8'h00);
        host_write(2'd2, 8'h00);
        host_write(2'd3, 8'h00);
        host_read(2'd1, d);
        check("R9 mask untouched", d, 16'h00FF);
        err_flags = 8'h08; step();
        host_read(2'd2, d);
        check("R9 unmapped reads zero", d, 16'h0000);
        check("R9 no clear addr2", {15'd0, err_n}, 16'd0);
        host_read(2'd3, d);
        check("R9 no clear addr3", {15'd0, err_n}, 16'd0);
        host_read(2'd0, d);
        check("R9 status kept", d, 16'h0008);
    endtask

    initial begin
        fork
            begin : watchdog
                repeat (5000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=finish");
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        join_none
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_and_read();
        t_multi_bits();
        t_mask();
        t_collide();
        t_ignored();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule